// File: doc/BRIEF.md
# Quad-Channel Serial Code Loader

This block is the digital front end of a four-channel 12-bit converter. A host writes a serial stream into a 48-bit shift register over three wires: a serial clock, a data line and a combined select/load line. When the select/load line rises, all four channel code registers take their values from the shift register in the same cycle. The four code buses are the only outputs toward the analog side.

Each frame carries the channel A field first, then B, C and D, with the most significant bit of each field first. The last stage of the shift register drives a serial output. Several devices can share the serial clock and select/load line and be chained data-out to data-in, so that one rising select/load edge updates the whole chain at once. While select/load is high, serial clock edges are ignored. An active-low clear input and the power-on reset both force every channel code to zero.

All three serial inputs are sampled by the block clock `clk` and are assumed to be synchronous to it. A serial clock rising edge is seen when `sclk` is sampled high after being sampled low.

Top module: `quad_code_loader`

## Requirements
- R1: When a rising `sclk` edge is sampled while `cs_ld` is sampled low, the shift register moves one place toward its last stage and takes `sdi` into stage 0, in that `clk` cycle.
- R2: After 48 shifts followed by a load, `code_a` holds the first 12 bits shifted, then `code_b`, `code_c` and `code_d` hold the following 12-bit groups, each field most significant bit first.
- R3: When a low-to-high transition of `cs_ld` is sampled, all four code outputs take the shift register contents together, visible after that same `clk` edge. At no other time do the codes change, except through clear or reset.
- R4: A rising `sclk` edge sampled while `cs_ld` is high does not shift. `sdo` and the contents loaded at the next load edge are unchanged by it.
- R5: `sdo` is the last stage of the shift register, so a bit shifted in appears on `sdo` after 48 shifts.
- R6: While `clr_n` is low, all four codes are zero, without waiting for a clock edge. The shift register keeps its contents, so a later load with no shifts in between restores the earlier frame.
- R7: A load edge sampled while `clr_n` is low leaves the codes at zero.
- R8: After `rst_n` is asserted, all codes and `sdo` are zero.
- R9: A load after more or fewer than 48 shifts takes the last 48 bits in the shift register. There is no framing check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial inputs |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| clr_n | input | 1 | Active-low clear of the channel codes, asynchronous |
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| sdi | input | 1 | Serial data in |
| cs_ld | input | 1 | Low enables shifting; a rising edge loads the codes |
| sdo | output | 1 | Serial data out, last stage of the shift register |
| code_a | output | CODE_W | Channel A code |
| code_b | output | CODE_W | Channel B code |
| code_c | output | CODE_W | Channel C code |
| code_d | output | CODE_W | Channel D code |

## Verification
A shift is due at the first `clk` edge that samples `sclk` high after a low sample. The new `sdo` is therefore compared at the falling edge that follows that rising edge. A load is due at the first edge that samples `cs_ld` high after a low sample. The scoreboard pops the expected frame one falling edge later and compares all four codes there. Clear acts without a clock, so the bench checks the codes 1 ns after `clr_n` falls, with no clock edge in between.

// File: rtl/quad_code_loader.sv
module quad_code_loader #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_ld,
  output logic              sdo,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] code_c,
  output logic [CODE_W-1:0] code_d
);
  localparam int CH      = 4;
  localparam int FRAME_W = CH * CODE_W;

  logic               sclk_q, cs_q;
  logic [FRAME_W-1:0] sr, hold;

  wire shift_en   = sclk & ~sclk_q & ~cs_ld;
  wire load_en    = cs_ld & ~cs_q;
  wire hold_rst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr     <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_ld;
      if (shift_en) sr <= {sr[FRAME_W-2:0], sdi};
    end

  always_ff @(posedge clk or negedge hold_rst_n)
    if (!hold_rst_n)  hold <= '0;
    else if (load_en) hold <= sr;

  assign sdo    = sr[FRAME_W-1];
  assign code_a = hold[4*CODE_W-1 -: CODE_W];
  assign code_b = hold[3*CODE_W-1 -: CODE_W];
  assign code_c = hold[2*CODE_W-1 -: CODE_W];
  assign code_d = hold[1*CODE_W-1 -: CODE_W];

  // R1
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !sclk_q && !cs_ld) |=> sdo == $past(sr[FRAME_W-2]));
  // R4
  gated_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_ld |=> $stable(sdo));
  // R3
  codes_hold_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
    !(cs_ld && !cs_q) |=> $stable({code_a, code_b, code_c, code_d}));
  // R6 R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> ({code_a, code_b, code_c, code_d} == '0));
endmodule

// File: tb/tb_quad_code_loader.sv
module tb_quad_code_loader;
  localparam int W = 12;
  localparam int F = 4 * W;

  logic clk = 1'b0, rst_n = 1'b0, clr_n = 1'b1, sclk = 1'b0, sdi = 1'b0, cs_ld = 1'b0;
  logic sdo;
  logic [W-1:0] code_a, code_b, code_c, code_d;

  int checks = 0, failures = 0;
  logic [F-1:0] model = '0;
  logic [F-1:0] exp_q[$];
  event loaded;

  quad_code_loader #(.CODE_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sclk(sclk), .sdi(sdi), .cs_ld(cs_ld),
    .sdo(sdo), .code_a(code_a), .code_b(code_b), .code_c(code_c), .code_d(code_d));

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [F-1:0] act, input logic [F-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [F-1:0] codes();
    return {code_a, code_b, code_c, code_d};
  endfunction

  // one serial bit: sclk high for one clk, low for one
  task automatic shift_bit(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    if (!cs_ld) model = {model[F-2:0], b};
    chk(sdo == model[F-1], cs_ld ? "R4 sdo gated" : "R1 R5 sdo shift",
        {{(F-1){1'b0}}, sdo}, {{(F-1){1'b0}}, model[F-1]});
  endtask

  task automatic send(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
  endtask

  task automatic do_load();
    @(negedge clk); cs_ld = 1'b1;
    @(negedge clk);
    exp_q.push_back(clr_n ? model : '0);
    -> loaded;
    @(negedge clk); cs_ld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(loaded);
      if (exp_q.size() != 0) begin
        logic [F-1:0] e;
        e = exp_q.pop_front();
        chk(codes() == e, "R3 R9 scoreboard load", codes(), e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [F-1:0] keep;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(codes() == '0 && sdo == 1'b0, "R8 reset", {codes()}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 field order
    send(64'h123_456_789_ABC, 48);
    do_load();
    chk(code_a == 12'h123 && code_b == 12'h456 && code_c == 12'h789 && code_d == 12'hABC,
        "R2 field order", codes(), 48'h123456789ABC);

    // R5: old frame emerges on sdo while new one enters (checked per bit)
    send(64'hFFF_000_A5A_5A5, 48);
    do_load();
    send(64'h800_001_7FF_C03, 48);
    do_load();

    // R4 clock gated while cs_ld high
    keep = model;
    @(negedge clk); cs_ld = 1'b1;
    @(negedge clk);
    send(64'h5A, 8);
    @(negedge clk); cs_ld = 1'b0;
    @(negedge clk);
    do_load();
    chk(codes() == keep, "R4 gated frame kept", codes(), keep);

    // R9 long and short frames
    send(64'h3_FED_CBA_987_654, 50);
    do_load();
    send(64'hB_4C3, 20);
    do_load();

    // R6 async clear, shift register kept
    keep = model;
    @(negedge clk); #1 clr_n = 1'b0;
    #1 chk(codes() == '0, "R6 async clear", codes(), '0);
    // R7 load during clear
    do_load();
    chk(codes() == '0, "R7 clear wins over load", codes(), '0);
    @(negedge clk); clr_n = 1'b1;
    do_load();
    chk(codes() == keep, "R6 shift register kept", codes(), keep);

    // R3 no change without load edge
    send(64'h111_222_333_444, 48);
    repeat (5) @(negedge clk);
    chk(codes() == keep, "R3 codes wait for load", codes(), keep);
    do_load();
    chk(codes() == 48'h111222333444, "R3 load updates all", codes(), 48'h111222333444);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule